// File: doc/BRIEF.md
# SPI Command Sequencer

This block is the control core of a serial peripheral interface. It takes write-only command words from a bus write port and turns each set bit into a one-cycle action: enable, disable, soft reset, FIFO on, FIFO off, transmit-FIFO flush, receive-FIFO flush and last-transfer. It keeps the enable state, issues start requests to a separate shift engine whenever the transmit holding register has data, and drives the chip-select line and the pin-direction control.

A disable never cuts a character short. If a character is being shifted when the disable arrives, the block holds the disable pending until the shift engine reports completion. It then turns itself off and starts nothing new, whatever the holding register contains. A last-transfer command arms a release of chip select. The release happens when the next character completes, even when chip select is configured to stay low between characters. A soft reset overrides everything else in the same write. It returns the block to its idle, disabled state, and its pulse tells the rest of the peripheral to return to client mode. The shifter and the FIFO storage are outside this block and are seen only through handshakes and pulses.

Top module: `spi_cmd_seq`

## Requirements
- R1: Writing a word with bit 0 set, and bits 1 and 7 clear, makes `enabled` high from the cycle after the write. A word with no command bit set, or with only non-command bits set, changes no output.
- R2: A word with both bit 0 (enable) and bit 1 (disable) set leaves the block disabled. With no character in flight, `enabled` is low in the cycle after the write.
- R3: A disable (bit 1) written while a character is in flight keeps `enabled` high until the cycle after the shift engine's `sh_done`. After that no `sh_start` is issued, even while `hold_valid` stays high. A later enable write does not cancel the pending disable.
- R4: `pins_oe` is high while enabled or while a character is in flight. It drops at the same edge at which a deferred disable takes effect.
- R5: A word with bit 7 (soft reset) set ignores all its other bits. In the cycle after the write, `srst_p` is high, `enabled` and `pins_oe` are low and `cs_n` is high, whatever was in flight. Pending disable and last-transfer requests are dropped.
- R6: With `cs_hold` high, `cs_n` stays low between characters. A last-transfer write (bit 24) raises `cs_n` at the edge where the next character to complete reports `sh_done`. If no character is in flight, that is the next character sent.
- R7: With `cs_hold` low, `cs_n` rises at the edge that sees `sh_done` for every character. The next start lowers it again one cycle later at the earliest.
- R8: Bit 30 produces `fifo_on_p` and bit 31 produces `fifo_off_p`, each acting on both FIFOs. When both are written together, only `fifo_off_p` pulses.
- R9: Bit 16 pulses `txf_clr_p` and bit 17 pulses `rxf_clr_p`, each on its own. Every action pulse lasts exactly one cycle, the cycle after the write.
- R10: `sh_start` is high in a cycle where the block is enabled, has no pending or incoming disable or soft reset, `hold_valid` is high and no character is in flight. `cs_n` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | CMD_W | Command word |
| hold_valid | input | 1 | Transmit holding register holds data |
| cs_hold | input | 1 | Keep chip select low between characters |
| sh_busy | input | 1 | Shift engine busy |
| sh_done | input | 1 | Shift engine finished a character (one cycle) |
| sh_start | output | 1 | Start request to the shift engine |
| cs_n | output | 1 | Active-low chip select |
| pins_oe | output | 1 | Interface pins driven (1) or input (0) |
| enabled | output | 1 | Block enabled |
| srst_p | output | 1 | Soft-reset pulse to the rest of the peripheral |
| fifo_on_p | output | 1 | Turn both FIFOs on |
| fifo_off_p | output | 1 | Turn both FIFOs off |
| txf_clr_p | output | 1 | Empty the transmit FIFO |
| rxf_clr_p | output | 1 | Empty the receive FIFO |

## Verification
A wrong pending-disable flag shows up within one character time. It appears as an extra `sh_start` after the character that should have been the last, or as `enabled` and `pins_oe` dropping while the shifter still reports busy. A lost or stale last-transfer flag shows up as `cs_n` staying low past a completed character, or rising a character early, at the edge after `sh_done`. Mis-decoded priority between bits shows up in the cycle right after the write, as a wrong pulse or a wrong `enabled` level.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int unsigned CMD_W  = 32;

    localparam int unsigned B_EN   = 0;
    localparam int unsigned B_DIS  = 1;
    localparam int unsigned B_SRST = 7;
    localparam int unsigned B_TXF  = 16;
    localparam int unsigned B_RXF  = 17;
    localparam int unsigned B_LAST = 24;
    localparam int unsigned B_FEN  = 30;
    localparam int unsigned B_FDIS = 31;

    typedef struct packed {
        logic srst;
        logic en;
        logic dis;
        logic txf;
        logic rxf;
        logic last;
        logic fen;
        logic fdis;
    } cmd_t;

    typedef struct packed {
        logic srst;
        logic fon;
        logic foff;
        logic txf;
        logic rxf;
    } pulse_t;

    localparam int unsigned PULSE_W = $bits(pulse_t);

    function automatic cmd_t cmd_decode(input logic [CMD_W-1:0] w, input logic valid);
        cmd_t c;
        c = '0;
        if (valid) begin
            if (w[B_SRST]) begin
                c.srst = 1'b1;
            end else begin
                c.dis  = w[B_DIS];
                c.en   = w[B_EN] & ~w[B_DIS];
                c.fdis = w[B_FDIS];
                c.fen  = w[B_FEN] & ~w[B_FDIS];
                c.txf  = w[B_TXF];
                c.rxf  = w[B_RXF];
                c.last = w[B_LAST];
            end
        end
        return c;
    endfunction

    function automatic pulse_t cmd_to_pulse(input cmd_t c);
        pulse_t p;
        p.srst = c.srst;
        p.fon  = c.fen;
        p.foff = c.fdis;
        p.txf  = c.txf;
        p.rxf  = c.rxf;
        return p;
    endfunction

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output cmd_t             act
);
    always_comb begin
        act = cmd_decode(wr_data, wr_en);
    end
endmodule

// File: rtl/spi_cmd_pulse.sv
module spi_cmd_pulse
    import spi_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmd_t   act,
    output pulse_t pls
);
    logic [PULSE_W-1:0] pls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pls_q <= '0;
        end else begin
            pls_q <= cmd_to_pulse(act);
        end
    end

    assign pls = pulse_t'(pls_q);
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t act,
    input  logic hold_valid,
    input  logic sh_busy,
    input  logic sh_done,
    output logic sh_start,
    output logic enabled,
    output logic in_flight,
    output logic dis_pend,
    output logic done_ev,
    output logic dis_apply,
    output logic pins_oe
);
    logic kill;
    logic hold_busy;
    logic want_off;

    assign kill      = rst | act.srst;
    assign done_ev   = in_flight & sh_done;
    assign hold_busy = in_flight & ~sh_done;
    assign want_off  = act.dis | dis_pend;
    assign dis_apply = want_off & ~hold_busy & ~act.srst;
    assign sh_start  = enabled & ~want_off & ~act.srst & hold_valid
                     & ~in_flight & ~sh_busy;
    assign pins_oe   = enabled | in_flight;

    always_ff @(posedge clk) begin
        if (kill) begin
            enabled   <= 1'b0;
            dis_pend  <= 1'b0;
            in_flight <= 1'b0;
        end else begin
            if (sh_start) begin
                in_flight <= 1'b1;
            end else if (done_ev) begin
                in_flight <= 1'b0;
            end
            if (dis_apply) begin
                enabled  <= 1'b0;
                dis_pend <= 1'b0;
            end else if (want_off) begin
                dis_pend <= 1'b1;
            end else if (act.en) begin
                enabled <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_cs.sv
module spi_cmd_cs
    import spi_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t act,
    input  logic cs_hold,
    input  logic sh_start,
    input  logic done_ev,
    input  logic dis_apply,
    output logic cs_n
);
    logic last_pend;
    logic end_char;

    assign end_char = done_ev & (~cs_hold | last_pend | act.last);

    always_ff @(posedge clk) begin
        if (rst | act.srst) begin
            cs_n      <= 1'b1;
            last_pend <= 1'b0;
        end else begin
            if (sh_start) begin
                cs_n <= 1'b0;
            end else if (end_char | dis_apply) begin
                cs_n <= 1'b1;
            end
            if (end_char) begin
                last_pend <= 1'b0;
            end else if (act.last) begin
                last_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int unsigned CW = CMD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          hold_valid,
    input  logic          cs_hold,
    input  logic          sh_busy,
    input  logic          sh_done,
    output logic          sh_start,
    output logic          cs_n,
    output logic          pins_oe,
    output logic          enabled,
    output logic          srst_p,
    output logic          fifo_on_p,
    output logic          fifo_off_p,
    output logic          txf_clr_p,
    output logic          rxf_clr_p
);
    cmd_t             act;
    pulse_t           pls;
    logic             in_flight;
    logic             dis_pend;
    logic             done_ev;
    logic             dis_apply;
    logic [CMD_W-1:0] word;

    generate
        if (CW >= CMD_W) begin : g_trim
            assign word = wr_data[CMD_W-1:0];
        end else begin : g_pad
            assign word = {{(CMD_W-CW){1'b0}}, wr_data};
        end
    endgenerate

    spi_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (word),
        .act     (act)
    );

    spi_cmd_pulse u_pls (
        .clk (clk),
        .rst (rst),
        .act (act),
        .pls (pls)
    );

    spi_cmd_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .hold_valid (hold_valid),
        .sh_busy    (sh_busy),
        .sh_done    (sh_done),
        .sh_start   (sh_start),
        .enabled    (enabled),
        .in_flight  (in_flight),
        .dis_pend   (dis_pend),
        .done_ev    (done_ev),
        .dis_apply  (dis_apply),
        .pins_oe    (pins_oe)
    );

    spi_cmd_cs u_cs (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cs_hold   (cs_hold),
        .sh_start  (sh_start),
        .done_ev   (done_ev),
        .dis_apply (dis_apply),
        .cs_n      (cs_n)
    );

    assign srst_p     = pls.srst;
    assign fifo_on_p  = pls.fon;
    assign fifo_off_p = pls.foff;
    assign txf_clr_p  = pls.txf;
    assign rxf_clr_p  = pls.rxf;
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk
    import spi_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CMD_W-1:0] word,
    input logic             cs_hold,
    input logic             sh_done,
    input logic             sh_start,
    input logic             cs_n,
    input logic             pins_oe,
    input logic             enabled,
    input logic             in_flight,
    input logic             dis_pend,
    input logic             srst_p,
    input logic             fifo_on_p,
    input logic             fifo_off_p
);
    assert_dis_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word[B_EN] && word[B_DIS] && !word[B_SRST] && !(in_flight && !sh_done))
        |=> !enabled);

    assert_no_start_pending_R3: assert property (@(posedge clk) disable iff (rst)
        dis_pend |-> !sh_start);

    assert_hold_in_flight_R3: assert property (@(posedge clk) disable iff (rst)
        (in_flight && !sh_done && !(wr_en && word[B_SRST])) |=> enabled);

    assert_pins_flight_R4: assert property (@(posedge clk) disable iff (rst)
        in_flight |-> pins_oe);

    assert_srst_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word[B_SRST]) |=> (srst_p && cs_n && !enabled && !in_flight && !dis_pend));

    assert_cs_release_R7: assert property (@(posedge clk) disable iff (rst)
        (in_flight && sh_done && !cs_hold) |=> cs_n);

    assert_fifo_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(fifo_on_p && fifo_off_p));

    assert_start_cs_R10: assert property (@(posedge clk) disable iff (rst)
        sh_start |=> !cs_n);
endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .word       (word),
    .cs_hold    (cs_hold),
    .sh_done    (sh_done),
    .sh_start   (sh_start),
    .cs_n       (cs_n),
    .pins_oe    (pins_oe),
    .enabled    (enabled),
    .in_flight  (in_flight),
    .dis_pend   (dis_pend),
    .srst_p     (srst_p),
    .fifo_on_p  (fifo_on_p),
    .fifo_off_p (fifo_off_p)
);

// File: tb/test_spi_cmd_seq.sv
`timescale 1ns/1ps
module test_spi_cmd_seq;
    localparam int LEN = 4;

    localparam logic [31:0] M_EN   = 32'h0000_0001;
    localparam logic [31:0] M_DIS  = 32'h0000_0002;
    localparam logic [31:0] M_SRST = 32'h0000_0080;
    localparam logic [31:0] M_TXF  = 32'h0001_0000;
    localparam logic [31:0] M_RXF  = 32'h0002_0000;
    localparam logic [31:0] M_LAST = 32'h0100_0000;
    localparam logic [31:0] M_FEN  = 32'h4000_0000;
    localparam logic [31:0] M_FDIS = 32'h8000_0000;
    localparam logic [31:0] M_ALL  = M_EN | M_DIS | M_SRST | M_TXF | M_RXF | M_LAST | M_FEN | M_FDIS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        hold_valid = 1'b0;
    logic        cs_hold = 1'b0;
    logic        sh_busy;
    logic        sh_done;
    logic        sh_start, cs_n, pins_oe, enabled;
    logic        srst_p, fifo_on_p, fifo_off_p, txf_clr_p, rxf_clr_p;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int eng_cnt = 0;

    always #5 clk = ~clk;

    spi_cmd_seq i_spi_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .hold_valid(hold_valid), .cs_hold(cs_hold), .sh_busy(sh_busy), .sh_done(sh_done),
        .sh_start(sh_start), .cs_n(cs_n), .pins_oe(pins_oe), .enabled(enabled),
        .srst_p(srst_p), .fifo_on_p(fifo_on_p), .fifo_off_p(fifo_off_p),
        .txf_clr_p(txf_clr_p), .rxf_clr_p(rxf_clr_p)
    );

    // shift engine model: busy LEN cycles, done in the last one
    always @(posedge clk) begin
        if (rst || srst_p) eng_cnt <= 0;
        else if (sh_start) eng_cnt <= LEN;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
    end
    assign sh_busy = (eng_cnt != 0);
    assign sh_done = (eng_cnt == 1);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        wr_data = w;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        #1;
    endtask

    function automatic logic [7:0] obs();
        return {srst_p, fifo_on_p, fifo_off_p, txf_clr_p, rxf_clr_p, enabled, cs_n, pins_oe};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_start, n_hi, n_lo, n_en, n_oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R5 reset state", int'(obs()), int'(8'b0000_0010));
        chk("R10 reset no start", int'(sh_start), 0);

        // sweep of all command-bit combinations, from disabled and enabled
        for (int pre = 0; pre < 2; pre++) begin
            for (int v = 0; v < 256; v++) begin
                logic [31:0] w;
                logic [7:0]  e;
                logic        s, en_e;
                do_write(M_SRST);
                if (pre == 1) do_write(M_EN);
                w = {v[7:0], v[7:0], v[7:0], v[7:0]} & ~M_ALL;
                if (v[0]) w |= M_EN;
                if (v[1]) w |= M_DIS;
                if (v[2]) w |= M_SRST;
                if (v[3]) w |= M_TXF;
                if (v[4]) w |= M_RXF;
                if (v[5]) w |= M_LAST;
                if (v[6]) w |= M_FEN;
                if (v[7]) w |= M_FDIS;
                s = v[2];
                en_e = s ? 1'b0 : (v[1] ? 1'b0 : (v[0] ? 1'b1 : pre[0]));
                e = {s, !s && v[6] && !v[7], !s && v[7], !s && v[3], !s && v[4], en_e, 1'b1, en_e};
                do_write(w);
                chk("R1 R2 R5 R8 R9 decode", int'(obs()), int'(e));
                @(negedge clk); #1;
                chk("R9 one-cycle pulse", int'(obs()), int'({5'b0, en_e, 1'b1, en_e}));
            end
        end

        // continuous characters with chip select released after each
        do_write(M_SRST);
        cs_hold = 1'b0;
        hold_valid = 1'b1;
        do_write(M_EN);
        n_start = 0; n_hi = 0;
        for (int c = 0; c < 50; c++) begin
            n_start += int'(sh_start);
            n_hi    += int'(cs_n);
            @(negedge clk); #1;
        end
        chk("R10 start count", n_start, 50 / (LEN + 1));
        chk("R7 cs high cycles", n_hi, 50 / (LEN + 1));

        // disable in the middle of a character, holding register kept full
        do_write(M_SRST);
        cs_hold = 1'b1;
        hold_valid = 1'b1;
        do_write(M_EN);
        chk("R10 first start", int'(sh_start), 1);
        @(negedge clk); @(negedge clk); #1;
        do_write(M_DIS);
        n_start = 0; n_en = 0; n_oe = 0; n_lo = 0;
        for (int c = 0; c < 10; c++) begin
            n_start += int'(sh_start);
            n_en    += int'(enabled);
            n_oe    += int'(pins_oe);
            n_lo    += int'(!cs_n);
            if (c == 0) do_write(M_EN); else begin @(negedge clk); #1; end
        end
        chk("R3 no start after disable", n_start, 0);
        chk("R3 enabled until done", n_en, LEN - 2);
        chk("R4 pins driven until done", n_oe, LEN - 2);
        chk("R4 cs low until done", n_lo, LEN - 2);
        chk("R3 stays disabled", int'(enabled), 0);

        // chip select held, then last-transfer armed while idle
        do_write(M_SRST);
        cs_hold = 1'b1;
        hold_valid = 1'b1;
        do_write(M_EN);
        @(negedge clk); #1;
        hold_valid = 1'b0;
        n_start = 0; n_lo = 0;
        for (int c = 0; c < 12; c++) begin
            n_start += int'(sh_start);
            n_lo    += int'(!cs_n);
            @(negedge clk); #1;
        end
        chk("R6 cs held between chars", n_lo, 12);
        chk("R10 no start without data", n_start, 0);
        do_write(M_LAST);
        chk("R6 cs waits for next char", int'(cs_n), 0);
        hold_valid = 1'b1;
        #1;
        chk("R10 start on data", int'(sh_start), 1);
        @(negedge clk); #1;
        hold_valid = 1'b0;
        n_lo = 0;
        for (int c = 0; c < 10; c++) begin
            n_lo += int'(!cs_n);
            @(negedge clk); #1;
        end
        chk("R6 cs released after last char", n_lo, LEN);
        chk("R6 still enabled", int'(enabled), 1);

        // soft reset mid-character overrides other bits
        do_write(M_SRST);
        cs_hold = 1'b1;
        hold_valid = 1'b1;
        do_write(M_EN);
        @(negedge clk); @(negedge clk); #1;
        do_write(M_SRST | M_EN | M_LAST | M_FEN | M_TXF);
        chk("R5 soft reset outputs", int'(obs()), int'(8'b1000_0010));
        n_start = 0; n_hi = 0;
        for (int c = 0; c < 10; c++) begin
            n_start += int'(sh_start);
            n_hi    += int'(cs_n);
            @(negedge clk); #1;
        end
        chk("R5 no start after reset", n_start, 0);
        chk("R5 cs high after reset", n_hi, 10);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule